// File: doc/BRIEF.md
# Serial Transmitter Break and Idle Sequencer

This block controls the line level of a serial transmitter while it sends break characters and idle preambles. A break holds the line low for a whole number of bit times. An idle preamble holds it high for one frame length. Software drives two control levels. A rising edge on the transmit-enable level queues an idle preamble. A rising edge on the send-break level queues a break. All durations are counted on a one-cycle baud tick that is supplied from outside, so every phase starts and ends on a bit boundary.

The break length depends on the configuration latched when the break starts:
- 10 bit times in 8-bit frame mode.
- 11 bit times in 9-bit frame mode.
- 13 bit times in LIN master mode with 8-bit frames.

After every break the line is held high for one bit time as a stop condition. If the send-break level is still high at the end of a break, another break follows that stop bit, so holding the level produces back-to-back breaks. A pending idle always wins over a pending break, so an idle requested with or just before a break runs to completion first, and the break that follows has exactly its nominal length. A one-cycle done pulse marks the end of each break and each idle, and a busy output covers both queued and running work.

Top module: `tx_break_gen`

## Requirements
- R1: With frame select 0 and LIN select 0, a break drives `tx` low for exactly 10 baud-tick periods.
- R2: With frame select 1, a break drives `tx` low for exactly 11 baud-tick periods, whatever the LIN select.
- R3: With LIN select 1 and frame select 0, a break drives `tx` low for exactly 13 baud-tick periods.
- R4: A rising edge on `send_brk` produces exactly one break, even when the pulse is one clock long and shorter than a bit time.
- R5: While `send_brk` stays high, breaks repeat back to back, and each one has the nominal length. Once the level is low at the end of a break, no further break follows.
- R6: After each break, `tx` is high for exactly one baud-tick period before a following break begins.
- R7: A rising edge on `tx_en` queues an idle preamble that keeps `tx` high for one frame length (10 or 11 bit times) and then pulses `done`. A falling edge of `tx_en` on its own queues nothing.
- R8: When an idle and a break are both pending, the idle is sent first. The break starts in the same cycle that the idle's `done` pulse appears, and it keeps its nominal length.
- R9: `done` is high for exactly one clock cycle at the end of every break and every idle.
- R10: While reset is asserted and after it is released, `tx` is high and `busy` and `done` are low until a request arrives.
- R11: `busy` is high from the cycle after a request edge until the last queued phase (including the stop bit) has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| nine_bit | input | 1 | Frame length select: 0 = 8 data bits, 1 = 9 data bits |
| lin_master | input | 1 | LIN master mode select |
| tx_en | input | 1 | Transmit-enable level; a rising edge queues an idle preamble |
| send_brk | input | 1 | Send-break level; a rising edge queues a break, and holding it repeats breaks |
| tx | output | 1 | Serial line output, high when idle |
| busy | output | 1 | A request is pending or a phase is running |
| done | output | 1 | One-cycle pulse at the end of each break and each idle |

## Verification
The idle request and the break request can land in the same clock cycle. The bench provokes this by raising `tx_en` and pulsing `send_brk` at the same edge. It judges the outcome by three things: the line stays high for one frame length, `done` pulses in the very cycle the line falls, and the low period that follows equals the nominal break length. The end of one break can also coincide with the resampling of a held `send_brk`. Holding that level across several breaks is checked by the stop gap being exactly one tick period and by every low period keeping its nominal length.

// File: rtl/txbrk_pkg.sv
package txbrk_pkg;

    typedef enum logic [1:0] {
        PH_REST     = 2'd0,
        PH_PREAMBLE = 2'd1,
        PH_BREAK    = 2'd2,
        PH_STOP     = 2'd3
    } phase_e;

    typedef struct packed {
        logic idle_pend;
        logic brk_pend;
    } pend_t;

    // Frame length in bit times: base length plus one for nine-bit frames.
    function automatic int unsigned frame_bits(input logic nine, input int unsigned base);
        return nine ? base + 1 : base;
    endfunction

    // Break length in bit times for the configuration selected at break start.
    function automatic int unsigned break_bits(input logic nine, input logic lin,
                                               input int unsigned base,
                                               input int unsigned lin_len);
        if (lin && !nine) return lin_len;
        return frame_bits(nine, base);
    endfunction

    // Counter width that can hold the largest phase length.
    function automatic int unsigned cnt_width(input int unsigned base, input int unsigned lin_len);
        int unsigned mx;
        mx = (lin_len > base + 1) ? lin_len : base + 1;
        return $clog2(mx + 1);
    endfunction

endpackage

// File: rtl/txbrk_req_capture.sv
module txbrk_req_capture
    import txbrk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_en,
    input  logic  send_brk,
    input  logic  take_idle,
    input  logic  take_brk,
    input  logic  brk_end,
    output pend_t pend
);
    logic en_q, brk_q;
    logic en_rise, brk_rise, brk_again;
    pend_t pend_q;

    assign en_rise   = tx_en && !en_q;
    assign brk_rise  = send_brk && !brk_q;
    assign brk_again = brk_end && send_brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            brk_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            en_q  <= tx_en;
            brk_q <= send_brk;
            if (en_rise)
                pend_q.idle_pend <= 1'b1;
            else if (take_idle)
                pend_q.idle_pend <= 1'b0;
            if (brk_rise || brk_again)
                pend_q.brk_pend <= 1'b1;
            else if (take_brk)
                pend_q.brk_pend <= 1'b0;
        end
    end

    assign pend = pend_q;

    // R4: a taken break request is consumed unless a new request arrives with it
    a_r4_brk_consumed: assert property (@(posedge clk) disable iff (rst)
        (take_brk && !brk_rise && !brk_again) |=> !pend_q.brk_pend);

    // R7: a lone falling edge of the enable never creates an idle request
    a_r7_no_idle_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!pend_q.idle_pend && !tx_en) |=> !pend_q.idle_pend);

endmodule

// File: rtl/txbrk_bit_timer.sv
module txbrk_bit_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] lim_in,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q, lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= CNT_W'(1);
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= lim_in;
        end else if (run && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = run && tick && (cnt_q == lim_q - CNT_W'(1));

    // R1: the bit counter never runs past the latched phase length
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < lim_q));

    // R3: the latched length does not move while a phase runs without reload
    a_r3_len_held: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> $stable(lim_q));

endmodule

// File: rtl/txbrk_seq_fsm.sv
module txbrk_seq_fsm
    import txbrk_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             last,
    input  pend_t            pend,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] brk_len,
    output phase_e           phase,
    output logic             run,
    output logic             load,
    output logic [CNT_W-1:0] load_len,
    output logic             take_idle,
    output logic             take_brk,
    output logic             brk_end,
    output logic             done
);
    phase_e ph_q, ph_d;
    logic   choose, pre_end, done_q;

    assign pre_end   = (ph_q == PH_PREAMBLE) && last;
    assign brk_end   = (ph_q == PH_BREAK) && last;
    assign choose    = (tick && (ph_q == PH_REST || ph_q == PH_STOP)) || pre_end;
    assign take_idle = choose && pend.idle_pend;
    assign take_brk  = choose && !pend.idle_pend && pend.brk_pend;
    assign load      = take_idle || take_brk;
    assign load_len  = take_idle ? frame_len : brk_len;
    assign run       = (ph_q == PH_PREAMBLE) || (ph_q == PH_BREAK);

    always_comb begin
        ph_d = ph_q;
        if (take_idle)
            ph_d = PH_PREAMBLE;
        else if (take_brk)
            ph_d = PH_BREAK;
        else if (brk_end)
            ph_d = PH_STOP;
        else if (choose)
            ph_d = PH_REST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_REST;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            done_q <= brk_end || pre_end;
        end
    end

    assign phase = ph_q;
    assign done  = done_q;

    // R6: a finished break is always followed by a stop bit
    a_r6_stop_follows_break: assert property (@(posedge clk) disable iff (rst)
        brk_end |=> (ph_q == PH_STOP));

    // R8: a pending idle is served ahead of any break
    a_r8_idle_first: assert property (@(posedge clk) disable iff (rst)
        (choose && pend.idle_pend) |=> (ph_q == PH_PREAMBLE));

    // R9: done never lasts longer than one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/tx_break_gen.sv
module tx_break_gen
    import txbrk_pkg::*;
#(
    parameter int unsigned BASE_BITS = 10,
    parameter int unsigned LIN_BITS  = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic baud_tick,
    input  logic nine_bit,
    input  logic lin_master,
    input  logic tx_en,
    input  logic send_brk,
    output logic tx,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = cnt_width(BASE_BITS, LIN_BITS);

    pend_t            pend;
    phase_e           phase;
    logic             run, load, last, take_idle, take_brk, brk_end;
    logic [CNT_W-1:0] frame_len, brk_len, load_len;

    assign frame_len = CNT_W'(frame_bits(nine_bit, BASE_BITS));
    assign brk_len   = CNT_W'(break_bits(nine_bit, lin_master, BASE_BITS, LIN_BITS));

    txbrk_req_capture u_req (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .send_brk  (send_brk),
        .take_idle (take_idle),
        .take_brk  (take_brk),
        .brk_end   (brk_end),
        .pend      (pend)
    );

    txbrk_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .run    (run),
        .load   (load),
        .lim_in (load_len),
        .last   (last)
    );

    txbrk_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .last      (last),
        .pend      (pend),
        .frame_len (frame_len),
        .brk_len   (brk_len),
        .phase     (phase),
        .run       (run),
        .load      (load),
        .load_len  (load_len),
        .take_idle (take_idle),
        .take_brk  (take_brk),
        .brk_end   (brk_end),
        .done      (done)
    );

    assign tx   = (phase != PH_BREAK);
    assign busy = (phase != PH_REST) || pend.idle_pend || pend.brk_pend;

    // R10: the line is high in the first cycle after reset
    a_r10_line_high_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx && !done));

    // R11: the line can only be low while busy is reported
    a_r11_low_implies_busy: assert property (@(posedge clk) disable iff (rst)
        !tx |-> busy);

endmodule

// File: tb/tb_tx_break_gen.sv
module tb_tx_break_gen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud_tick = 1'b0;
    logic nine_bit = 1'b0;
    logic lin_master = 1'b0;
    logic tx_en = 1'b0;
    logic send_brk = 1'b0;
    logic tx, busy, done;

    int period = 2;
    int tick_ctr = 0;
    int vectors = 0;
    int fails = 0;

    tx_break_gen dut (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .nine_bit   (nine_bit),
        .lin_master (lin_master),
        .tx_en      (tx_en),
        .send_brk   (send_brk),
        .tx         (tx),
        .busy       (busy),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (tick_ctr >= period - 1) begin
            tick_ctr  <= 0;
            baud_tick <= 1'b1;
        end else begin
            tick_ctr  <= tick_ctr + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (nine=%0b lin=%0b P=%0d)",
                     req, act, exp, nine_bit, lin_master, period);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        vectors++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d (P=%0d)", req, act, lo, hi, period);
        end
    endtask

    function automatic int exp_brk(input logic nine, input logic lin);
        if (lin && !nine) return 13;
        return nine ? 11 : 10;
    endfunction

    function automatic string brk_tag(input logic nine, input logic lin);
        if (lin && !nine) return "R3";
        return nine ? "R2" : "R1";
    endfunction

    task automatic watch(input int n, output int lows, output int falls, output int dones,
                         output int first_fall, output int first_done, output int done_at_fall);
        logic prev;
        lows = 0; falls = 0; dones = 0; first_fall = -1; first_done = -1; done_at_fall = 0;
        prev = tx;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (!tx) lows++;
            if (prev && !tx) begin
                falls++;
                if (first_fall < 0) begin
                    first_fall = i;
                    done_at_fall = done ? 1 : 0;
                end
            end
            if (done) begin
                dones++;
                if (first_done < 0) first_done = i;
            end
            prev = tx;
        end
    endtask

    task automatic settle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic single_break(input logic nine, input logic lin, input int p);
        int lows, falls, dones, ff, fd, daf, b;
        nine_bit = nine; lin_master = lin; period = p;
        settle();
        b = exp_brk(nine, lin);
        send_brk = 1'b1;
        @(negedge clk);
        send_brk = 1'b0;
        chk("R11 busy after request", busy, 1);
        watch(2 * (b + 3) * p + 10, lows, falls, dones, ff, fd, daf);
        chk(brk_tag(nine, lin), lows, b * p);
        chk("R4 one break per pulse", falls, 1);
        chk("R9 one done per break", dones, 1);
        chk("R11 busy clears", busy, 0);
        chk("R10 line high at rest", tx, 1);
    endtask

    task automatic held_break(input logic nine, input logic lin, input int p);
        int lowc, gap, guard, b, lows, falls, dones, ff, fd, daf;
        nine_bit = nine; lin_master = lin; period = p;
        settle();
        b = exp_brk(nine, lin);
        send_brk = 1'b1;
        guard = 0;
        while (tx && guard < 1000) begin @(negedge clk); guard++; end
        for (int k = 0; k < 2; k++) begin
            lowc = 0;
            while (!tx && lowc < 1000) begin @(negedge clk); lowc++; end
            chk("R5 repeated break length", lowc, b * p);
            gap = 0;
            while (tx && gap < 1000) begin @(negedge clk); gap++; end
            chk("R6 stop gap one bit", gap, p);
        end
        send_brk = 1'b0;
        lowc = 0;
        while (!tx && lowc < 1000) begin @(negedge clk); lowc++; end
        chk("R5 final break length", lowc, b * p);
        settle();
        watch((b + 3) * p + 10, lows, falls, dones, ff, fd, daf);
        chk("R5 no break after release", falls, 0);
    endtask

    task automatic idle_only(input logic nine, input int p);
        int lows, falls, dones, ff, fd, daf, l;
        nine_bit = nine; lin_master = 1'b0; period = p;
        tx_en = 1'b0;
        settle();
        l = nine ? 11 : 10;
        tx_en = 1'b1;
        watch((l + 3) * p + 10, lows, falls, dones, ff, fd, daf);
        chk("R7 idle keeps line high", lows, 0);
        chk("R9 one done per idle", dones, 1);
        chk_range("R7 idle length", fd, l * p + 2, l * p + p + 1);
        tx_en = 1'b0;
        watch(3 * p + 20, lows, falls, dones, ff, fd, daf);
        chk("R7 falling enable no done", dones, 0);
        chk("R7 falling enable not busy", busy, 0);
    endtask

    task automatic idle_then_break(input logic nine, input logic lin, input int p);
        int lows, falls, dones, ff, fd, daf, l, b;
        nine_bit = nine; lin_master = lin; period = p;
        tx_en = 1'b0;
        settle();
        l = nine ? 11 : 10;
        b = exp_brk(nine, lin);
        tx_en = 1'b1;
        send_brk = 1'b1;
        @(negedge clk);
        send_brk = 1'b0;
        watch((l + b + 4) * p + 10, lows, falls, dones, ff, fd, daf);
        chk("R8 break follows idle at done", daf, 1);
        chk("R8 break nominal length", lows, b * p);
        chk("R8 two done pulses", dones, 2);
        chk_range("R8 idle before break", ff, l * p + 1, l * p + p);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 tx high in reset", tx, 1);
        chk("R10 busy low in reset", busy, 0);
        chk("R10 done low in reset", done, 0);
        rst = 1'b0;
        repeat (30) begin
            @(negedge clk);
            chk("R10 quiet after reset", {tx, busy, done}, 3'b100);
        end
        for (int m = 0; m < 4; m++) begin
            for (int pi = 1; pi <= 5; pi++) begin
                if (pi != 4) single_break(m[0], m[1], pi);
            end
        end
        for (int m = 0; m < 4; m++) begin
            held_break(m[0], m[1], 2);
            held_break(m[0], m[1], 3);
        end
        idle_only(1'b0, 2);
        idle_only(1'b1, 3);
        idle_only(1'b0, 1);
        for (int m = 0; m < 4; m++) begin
            idle_then_break(m[0], m[1], 2);
            idle_then_break(m[0], m[1], 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule